// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps the time of day and the calendar date in packed BCD registers. A single-cycle tick, one per second, moves the count on by one second. Every carry ripples through: seconds into minutes, minutes into a 24-hour hour count, and a day rollover into a one-hot weekday, a day of month whose length depends on the month and on a leap-year rule, a month from 1 to 12, and a two-digit year.

Software loads the registers through a single-cycle parallel write port and reads them through a combinational read port. A control register provides a freeze bit, so the clock can be stopped while a new time is loaded. A flag register provides an update flag that marks every advance, so a reader can detect a read torn by a rollover and retry. It also holds a voltage-low flag that shows whether the time can be trusted. The timer and alarm flags and the interrupt enables are plain storage.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the registers read as follows: seconds, minutes, hours and year 0x00; weekday 0x01; day of month 0x01; month 0x01; scratch 0x00; flags 0x02; control 0x00.
- R2: Each accepted tick adds one to the seconds register (address 0x0) in BCD. Seconds 0x59 wrap to 0x00 and carry into minutes (0x1). Minutes 0x59 wrap and carry into hours (0x2). Hours 0x23 wrap to 0x00.
- R3: On a day carry (23:59:59 plus one tick), the weekday register (0x3, 7-bit one-hot) rotates left by one, with bit 6 going to bit 0. The day of month (0x4) goes up by one in BCD.
- R4: The day of month returns to 0x01 and the month (0x5) advances after day 0x31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 0x30 in months 04, 06, 09 and 11. For February (0x02) this happens after day 0x29 when the year (0x6) is divisible by 4, and after day 0x28 otherwise. Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R5: While control bit 1 (freeze) is 1, ticks leave every time and date register unchanged. Counting resumes once the bit is written back to 0.
- R6: Flag bit 5 (update) sets on every advance. Writing 0 to it clears it. Writing 1 to it does not set it.
- R7: Flag bit 1 (voltage low) sets at reset and in any cycle where `powerFail` is high. It is cleared only by writing 0 to it.
- R8: A tick that arrives in the same cycle as any write is dropped. The write takes effect and no register advances.
- R9: Writes are masked to the field widths: seconds and minutes 7 bits, hours 6, weekday 7, day of month 6, month 5, year and scratch (0x7) 8. Control (0xF) keeps bits 5, 4, 3, 1 and 0. Flag bits 4 and 3 (0xE) store the written value. Addresses 0x8 to 0xD read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickPps | input | 1 | One-cycle pulse, once per second |
| powerFail | input | 1 | Supply-fail indication; sets the voltage-low flag |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 8 | Combinational read data |

## Verification
The bench builds the block with its default address width of 4, which gives the full 16-entry map, including the unused addresses that must read zero. Each tick is a direct input pulse and any register can be preloaded. This puts every month-end, the February leap and non-leap cases, the year-00 leap case and the 99-to-00 year wrap within one tick of a loaded 23:59:59. The freeze bit, the update and voltage-low flag rules and the write-versus-tick collision are each exercised at the port.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int MAP_ADDR_W = 4;
  localparam int MAP_SIZE   = 1 << MAP_ADDR_W;

  typedef enum logic [MAP_ADDR_W-1:0] {
    A_SEC     = 4'h0,
    A_MIN     = 4'h1,
    A_HOUR    = 4'h2,
    A_WDAY    = 4'h3,
    A_MDAY    = 4'h4,
    A_MONTH   = 4'h5,
    A_YEAR    = 4'h6,
    A_SCRATCH = 4'h7,
    A_FLAGS   = 4'hE,
    A_CTRL    = 4'hF
  } calAddr_e;

  // flag and control bit positions
  localparam int F_UPD  = 5;
  localparam int F_TMR  = 4;
  localparam int F_ALM  = 3;
  localparam int F_VLOW = 1;
  localparam int C_STOP = 1;

  localparam logic [7:0] CTRL_MASK = 8'h3B;

  typedef struct packed {
    logic                advance;
    logic [MAP_SIZE-1:0] wrSel;
  } calStrobe_t;
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              tickPps,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              stopBit,
  output calStrobe_t        strb
);
  // one write select per map entry
  for (genvar i = 0; i < MAP_SIZE; i++) begin : g_sel
    assign strb.wrSel[i] = wrEn && (wrAddr == ADDR_W'(i));
  end

  // a write in the same cycle drops the tick
  assign strb.advance = tickPps && !stopBit && !wrEn;
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WDAY_N = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strb,
  input  logic              powerFail,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              stopBit
);
  logic [7:0] secReg, minReg, hourReg, mdayReg, monReg, yearReg, scratchReg, ctrlReg;
  logic [WDAY_N-1:0] wdayReg;
  logic updF, tmrF, almF, vlowF;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leapYear(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] monthEnd(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leapYear(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  logic secWrap, minWrap, hourWrap, mdayWrap, monWrap, yearWrap, dayCarry;
  always_comb begin
    secWrap  = secReg  == 8'h59;
    minWrap  = minReg  == 8'h59;
    hourWrap = hourReg == 8'h23;
    mdayWrap = mdayReg == monthEnd(monReg, yearReg);
    monWrap  = monReg  == 8'h12;
    yearWrap = yearReg == 8'h99;
    dayCarry = secWrap && minWrap && hourWrap;
  end

  // time and date counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secReg  <= 8'h00;
      minReg  <= 8'h00;
      hourReg <= 8'h00;
      wdayReg <= WDAY_N'(1);
      mdayReg <= 8'h01;
      monReg  <= 8'h01;
      yearReg <= 8'h00;
    end else if (strb.advance) begin
      secReg <= secWrap ? 8'h00 : bcdInc(secReg);
      if (secWrap) minReg <= minWrap ? 8'h00 : bcdInc(minReg);
      if (secWrap && minWrap) hourReg <= hourWrap ? 8'h00 : bcdInc(hourReg);
      if (dayCarry) begin
        wdayReg <= {wdayReg[WDAY_N-2:0], wdayReg[WDAY_N-1]};
        mdayReg <= mdayWrap ? 8'h01 : bcdInc(mdayReg);
        if (mdayWrap) begin
          monReg <= monWrap ? 8'h01 : bcdInc(monReg);
          if (monWrap) yearReg <= yearWrap ? 8'h00 : bcdInc(yearReg);
        end
      end
    end else begin
      if (strb.wrSel[A_SEC])   secReg  <= wrData & 8'h7F;
      if (strb.wrSel[A_MIN])   minReg  <= wrData & 8'h7F;
      if (strb.wrSel[A_HOUR])  hourReg <= wrData & 8'h3F;
      if (strb.wrSel[A_WDAY])  wdayReg <= wrData[WDAY_N-1:0];
      if (strb.wrSel[A_MDAY])  mdayReg <= wrData & 8'h3F;
      if (strb.wrSel[A_MONTH]) monReg  <= wrData & 8'h1F;
      if (strb.wrSel[A_YEAR])  yearReg <= wrData;
    end
  end

  // scratch, control and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scratchReg <= 8'h00;
      ctrlReg    <= 8'h00;
      updF       <= 1'b0;
      tmrF       <= 1'b0;
      almF       <= 1'b0;
      vlowF      <= 1'b1;
    end else begin
      if (strb.wrSel[A_SCRATCH]) scratchReg <= wrData;
      if (strb.wrSel[A_CTRL])    ctrlReg    <= wrData & CTRL_MASK;
      if (strb.wrSel[A_FLAGS]) begin
        updF  <= updF  && wrData[F_UPD];
        tmrF  <= wrData[F_TMR];
        almF  <= wrData[F_ALM];
        vlowF <= vlowF && wrData[F_VLOW];
      end
      if (strb.advance) updF  <= 1'b1;
      if (powerFail)    vlowF <= 1'b1;
    end
  end

  assign stopBit = ctrlReg[C_STOP];

  always_comb begin
    rdData = 8'h00;
    case (rdAddr)
      ADDR_W'(A_SEC):     rdData = secReg;
      ADDR_W'(A_MIN):     rdData = minReg;
      ADDR_W'(A_HOUR):    rdData = hourReg;
      ADDR_W'(A_WDAY):    rdData = 8'(wdayReg);
      ADDR_W'(A_MDAY):    rdData = mdayReg;
      ADDR_W'(A_MONTH):   rdData = monReg;
      ADDR_W'(A_YEAR):    rdData = yearReg;
      ADDR_W'(A_SCRATCH): rdData = scratchReg;
      ADDR_W'(A_FLAGS):   rdData = {2'b00, updF, tmrF, almF, 1'b0, vlowF, 1'b0};
      ADDR_W'(A_CTRL):    rdData = ctrlReg;
      default:            rdData = 8'h00;
    endcase
  end

  logic [8*6+WDAY_N-1:0] timeVec;
  assign timeVec = {secReg, minReg, hourReg, wdayReg, mdayReg, monReg, yearReg};

  // R5: freeze holds every time and date register
  a_r5_stop_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (stopBit && !(|strb.wrSel[6:0])) |=> $stable(timeVec));

  // R6: every advance leaves the update flag set
  a_r6_update_sets: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> updF);

  // R7: power fail forces the voltage-low flag
  a_r7_vlow_on_fail: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> vlowF);

  // R3: weekday rotates left at the day carry
  a_r3_wday_rotates: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && dayCarry) |=>
      (wdayReg == {$past(wdayReg[WDAY_N-2:0]), $past(wdayReg[WDAY_N-1])}));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickPps,
  input  logic              powerFail,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);
  calStrobe_t strb;
  logic stopBit;

  cal_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .tickPps (tickPps),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .stopBit (stopBit),
    .strb    (strb)
  );

  cal_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .powerFail (powerFail),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .stopBit   (stopBit)
  );

  // R8: a tick colliding with a write elsewhere leaves seconds untouched
  a_r8_write_drops_tick: assert property (@(posedge clk) disable iff (!rstN)
    (tickPps && wrEn && wrAddr != ADDR_W'(A_SEC)) |=> $stable(u_dp.secReg));
endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickPps = 1'b0;
  logic powerFail = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = 4'h0;
  logic [7:0] wrData = 8'h00;
  logic [3:0] rdAddr = 4'h0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;

  bcd_calendar #(.ADDR_W(4)) i_bcd_calendar (
    .clk(clk), .rstN(rstN), .tickPps(tickPps), .powerFail(powerFail),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    rdAddr = a;
    #1;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s addr %h: got %h expected %h", req, a, rdData, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    tickPps = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tickPps = 1'b0;
  endtask

  task automatic loadDate(input logic [7:0] mon, input logic [7:0] mday, input logic [7:0] yr);
    wr(4'h0, 8'h59); wr(4'h1, 8'h59); wr(4'h2, 8'h23);
    wr(4'h5, mon); wr(4'h4, mday); wr(4'h6, yr);
  endtask

  task automatic testReset();
    chk(4'h0, 8'h00, "R1"); chk(4'h1, 8'h00, "R1"); chk(4'h2, 8'h00, "R1");
    chk(4'h3, 8'h01, "R1"); chk(4'h4, 8'h01, "R1"); chk(4'h5, 8'h01, "R1");
    chk(4'h6, 8'h00, "R1"); chk(4'h7, 8'h00, "R1");
    chk(4'hE, 8'h02, "R1"); chk(4'hF, 8'h00, "R1");
  endtask

  task automatic testClock();
    wr(4'h0, 8'h58);
    tick(); chk(4'h0, 8'h59, "R2");
    chk(4'hE, 8'h22, "R6 update set");
    tick(); chk(4'h0, 8'h00, "R2"); chk(4'h1, 8'h01, "R2");
    wr(4'h0, 8'h09); tick(); chk(4'h0, 8'h10, "R2 digit carry");
    wr(4'h0, 8'h59); wr(4'h1, 8'h59); wr(4'h2, 8'h09);
    tick(); chk(4'h2, 8'h10, "R2 hour"); chk(4'h1, 8'h00, "R2");
  endtask

  task automatic testDay();
    loadDate(8'h03, 8'h15, 8'h24);
    wr(4'h3, 8'h40);
    tick();
    chk(4'h0, 8'h00, "R2"); chk(4'h1, 8'h00, "R2"); chk(4'h2, 8'h00, "R2 hour wrap");
    chk(4'h3, 8'h01, "R3 weekday wrap"); chk(4'h4, 8'h16, "R3");
    tick(); chk(4'h3, 8'h01, "R3 no day carry");
    loadDate(8'h03, 8'h16, 8'h24);
    wr(4'h3, 8'h04); tick(); chk(4'h3, 8'h08, "R3 rotate");
  endtask

  task automatic monthCase(input logic [7:0] mon, input logic [7:0] mday, input logic [7:0] yr,
                           input logic [7:0] expMon, input logic [7:0] expDay, input logic [7:0] expYr);
    loadDate(mon, mday, yr);
    tick();
    chk(4'h4, expDay, "R4 day"); chk(4'h5, expMon, "R4 month"); chk(4'h6, expYr, "R4 year");
  endtask

  task automatic testMonths();
    monthCase(8'h01, 8'h31, 8'h23, 8'h02, 8'h01, 8'h23);
    monthCase(8'h01, 8'h30, 8'h23, 8'h01, 8'h31, 8'h23);
    monthCase(8'h04, 8'h30, 8'h23, 8'h05, 8'h01, 8'h23);
    monthCase(8'h11, 8'h30, 8'h23, 8'h12, 8'h01, 8'h23);
    monthCase(8'h08, 8'h31, 8'h23, 8'h09, 8'h01, 8'h23);
    monthCase(8'h02, 8'h28, 8'h23, 8'h03, 8'h01, 8'h23);
    monthCase(8'h02, 8'h28, 8'h24, 8'h02, 8'h29, 8'h24);
    monthCase(8'h02, 8'h29, 8'h24, 8'h03, 8'h01, 8'h24);
    monthCase(8'h02, 8'h28, 8'h00, 8'h02, 8'h29, 8'h00);
    monthCase(8'h02, 8'h28, 8'h16, 8'h02, 8'h29, 8'h16);
    monthCase(8'h02, 8'h28, 8'h30, 8'h03, 8'h01, 8'h30);
    monthCase(8'h12, 8'h31, 8'h41, 8'h01, 8'h01, 8'h42);
    monthCase(8'h12, 8'h31, 8'h99, 8'h01, 8'h01, 8'h00);
  endtask

  task automatic testStop();
    wr(4'h0, 8'h30);
    wr(4'hF, 8'h02);
    chk(4'hF, 8'h02, "R5 ctrl");
    tick(); tick(); tick();
    chk(4'h0, 8'h30, "R5 frozen");
    wr(4'hF, 8'h00);
    tick(); chk(4'h0, 8'h31, "R5 resumed");
  endtask

  task automatic testFlags();
    wr(4'hE, 8'h00); chk(4'hE, 8'h00, "R6 R7 clear");
    wr(4'hE, 8'h22); chk(4'hE, 8'h00, "R6 R7 no software set");
    tick(); chk(4'hE, 8'h20, "R6");
    wr(4'hE, 8'h38); chk(4'hE, 8'h38, "R6 write 1 keeps / R9 storage");
    wr(4'hE, 8'h18); chk(4'hE, 8'h18, "R6 cleared R9 storage");
    powerFail = 1'b1; @(posedge clk); @(negedge clk); powerFail = 1'b0;
    chk(4'hE, 8'h1A, "R7 power fail");
    wr(4'hE, 8'h1A); chk(4'hE, 8'h1A, "R7 held");
    wr(4'hE, 8'h00); chk(4'hE, 8'h00, "R7 cleared");
  endtask

  task automatic testCollision();
    wr(4'h0, 8'h10);
    tickPps = 1'b1; wrEn = 1'b1; wrAddr = 4'h7; wrData = 8'hA5;
    @(posedge clk); @(negedge clk);
    tickPps = 1'b0; wrEn = 1'b0;
    chk(4'h0, 8'h10, "R8 tick dropped"); chk(4'h7, 8'hA5, "R8 write taken");
    chk(4'hE, 8'h00, "R8 no update flag");
    tickPps = 1'b1; wrEn = 1'b1; wrAddr = 4'h0; wrData = 8'h44;
    @(posedge clk); @(negedge clk);
    tickPps = 1'b0; wrEn = 1'b0;
    chk(4'h0, 8'h44, "R8 write wins on seconds");
  endtask

  task automatic testMasks();
    wr(4'h0, 8'hFF); chk(4'h0, 8'h7F, "R9 sec mask");
    wr(4'h1, 8'hFF); chk(4'h1, 8'h7F, "R9 min mask");
    wr(4'h2, 8'hFF); chk(4'h2, 8'h3F, "R9 hour mask");
    wr(4'h3, 8'hFF); chk(4'h3, 8'h7F, "R9 weekday mask");
    wr(4'h4, 8'hFF); chk(4'h4, 8'h3F, "R9 mday mask");
    wr(4'h5, 8'hFF); chk(4'h5, 8'h1F, "R9 month mask");
    wr(4'h6, 8'hFF); chk(4'h6, 8'hFF, "R9 year");
    wr(4'hF, 8'hFD); chk(4'hF, 8'h39, "R9 ctrl mask");
    wr(4'hF, 8'h00);
    wr(4'h8, 8'h55); chk(4'h8, 8'h00, "R9 unused");
    wr(4'hD, 8'h55); chk(4'hD, 8'h00, "R9 unused");
    chk(4'h7, 8'hA5, "R9 unused write no side effect");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClock();
    testDay();
    testMonths();
    testStop();
    testFlags();
    testCollision();
    testMasks();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule